// File: doc/BRIEF.md
# Misaligned Data Alignment Unit

This unit lets a pipeline read a 64-bit quantity that does not start on an 8-byte boundary, using two cooperating operations and a small status register. The address operation adds a base and a displacement. It returns the sum rounded down to the enclosing 8-byte boundary, so that two aligned fetches can be made. It also records the three discarded low bits of the sum as a byte offset in the status register.

The extract operation then takes the two aligned 64-bit words that were fetched. It treats them as one 16-byte big-endian string {first, second} and returns the eight consecutive bytes that begin at the recorded offset. Byte 0 of the string is bits [63:56] of the first word. Both operations return a registered result one cycle after issue, and a valid flag follows the issue flag.

The status register can also be written directly, so that software can save and restore the offset. A direct write and an address operation in the same cycle resolve in favour of the address operation.

Top module: `unaligned_extract_unit`

## Requirements
- R1: An address operation (op code 2'b01) returns the 64-bit sum of opnd_a and opnd_b, wrapping modulo 2^64, with bits [2:0] forced to zero.
- R2: An address operation loads bits [2:0] of that sum into status bits [2:0] and leaves status bits [7:3] unchanged.
- R3: An extract operation (op code 2'b10) with offset k in status bits [2:0] returns bytes k to k+7 of the 16-byte string {opnd_a, opnd_b}. Byte 0 is opnd_a[63:56], byte 8 is opnd_b[63:56], and the first selected byte lands in result[63:56].
- R4: An extract operation with offset zero returns opnd_a exactly, whatever opnd_b holds.
- R5: result and out_valid change one clock edge after issue. out_valid equals in_valid of the previous cycle, and result holds its value in a cycle with in_valid low.
- R6: Synchronous active-high reset clears the status register, result and out_valid.
- R7: An extract operation issued in the cycle directly after an address operation uses the offset produced by that address operation.
- R8: A direct write (stat_we high) loads all 8 status bits on the next edge. When it coincides with a valid address operation, the direct write is discarded and the address operation's update applies.
- R9: An extract operation uses the offset held at the start of its cycle, even when a direct write occurs in the same cycle, and it never changes the status register.
- R10: Op codes 2'b00 and 2'b11 return zero and change no status. Any operation issued with in_valid low changes neither the status register nor the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue an operation this cycle |
| in_op | input | 2 | Operation code: 01 address, 10 extract, 00/11 null |
| opnd_a | input | 64 | Base address, or first (high) data word |
| opnd_b | input | 64 | Displacement, or second (low) data word |
| stat_we | input | 1 | Direct write strobe for the status register |
| stat_wdata | input | 8 | Direct write value |
| result | output | 64 | Registered operation result |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| stat_rd | output | 8 | Current status register; bits [2:0] are the byte offset |

## Verification
The hardest situations to reach from the ports are the same-cycle interactions around the status register. These are an address operation colliding with a direct write, an extract that shares its cycle with a direct write, and an extract issued immediately behind the address operation that produced its offset. The stimulus drives these inputs together, in adjacent or identical cycles, with status upper bits deliberately non-zero. This shows which source won, and whether the upper bits survived. All eight offsets are swept with a byte-ramp data pattern, so a wrong lane or a wrong direction is visible in the returned word.

// File: rtl/uxa_pkg.sv
package uxa_pkg;

    localparam int unsigned DATA_W = 64;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned LANES  = DATA_W / BYTE_W;
    localparam int unsigned OFS_W  = $clog2(LANES);
    localparam int unsigned STAT_W = 8;

    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_ADDR = 2'b01,
        OP_EXTR = 2'b10,
        OP_RSVD = 2'b11
    } op_e;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } rslt_t;

    // Round a word down to the enclosing lane-group boundary.
    function automatic logic [DATA_W-1:0] align_down(input logic [DATA_W-1:0] x);
        return {x[DATA_W-1:OFS_W], {OFS_W{1'b0}}};
    endfunction

endpackage

// File: rtl/uxa_addr_gen.sv
module uxa_addr_gen
    import uxa_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter int unsigned OW = OFS_W
) (
    input  logic [DW-1:0] base,
    input  logic [DW-1:0] disp,
    output logic [DW-1:0] aligned,
    output logic [OW-1:0] ofs
);

    logic [DW-1:0] sum;

    always_comb begin
        sum     = base + disp;
        aligned = align_down(sum);
        ofs     = sum[OW-1:0];
    end

endmodule

// File: rtl/uxa_byte_funnel.sv
module uxa_byte_funnel
    import uxa_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter int unsigned BW = BYTE_W,
    parameter int unsigned OW = OFS_W
) (
    input  logic [DW-1:0] hi,
    input  logic [DW-1:0] lo,
    input  logic [OW-1:0] ofs,
    output logic [DW-1:0] out
);

    localparam int unsigned NL = DW / BW;

    // Big-endian byte view of the 2*NL-byte string {hi, lo}.
    logic [BW-1:0] cat_byte [2*NL];

    for (genvar i = 0; i < 2*NL; i++) begin : g_split
        if (i < NL) begin : g_hi
            assign cat_byte[i] = hi[DW-1-i*BW -: BW];
        end else begin : g_lo
            assign cat_byte[i] = lo[DW-1-(i-NL)*BW -: BW];
        end
    end

    // Each output lane selects one byte of the string.
    for (genvar j = 0; j < NL; j++) begin : g_lane
        logic [BW-1:0] pick;
        always_comb begin
            pick = '0;
            for (int k = 0; k < NL; k++) begin
                if (ofs == OW'(k)) pick = cat_byte[j+k];
            end
        end
        assign out[DW-1-j*BW -: BW] = pick;
    end

    // R4: a zero offset passes the high word through untouched
    always_comb begin
        if (ofs == '0) begin
            a_r4_zero_ofs_passthru: assert (out == hi);
        end
    end

endmodule

// File: rtl/uxa_status_reg.sv
module uxa_status_reg
    import uxa_pkg::*;
#(
    parameter int unsigned SW = STAT_W,
    parameter int unsigned OW = OFS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dir_we,
    input  logic [SW-1:0] dir_wdata,
    input  logic          addr_we,
    input  logic [OW-1:0] addr_ofs,
    output logic [SW-1:0] stat
);

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
        end else if (addr_we) begin
            stat[OW-1:0] <= addr_ofs;
        end else if (dir_we) begin
            stat <= dir_wdata;
        end
    end

    // R2: address update lands in the field, upper bits survive (also R8 priority)
    a_r2_upper_kept: assert property (@(posedge clk) disable iff (rst)
        addr_we |=> (stat[OW-1:0] == $past(addr_ofs)) &&
                    (stat[SW-1:OW] == $past(stat[SW-1:OW])));

    // R8: a lone direct write loads every bit
    a_r8_direct_load: assert property (@(posedge clk) disable iff (rst)
        (dir_we && !addr_we) |=> (stat == $past(dir_wdata)));

    // R9: with no writer the register holds
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (!dir_we && !addr_we) |=> $stable(stat));

endmodule

// File: rtl/unaligned_extract_unit.sv
module unaligned_extract_unit
    import uxa_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter int unsigned BW = BYTE_W,
    parameter int unsigned SW = STAT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [1:0]    in_op,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    input  logic          stat_we,
    input  logic [SW-1:0] stat_wdata,
    output logic [DW-1:0] result,
    output logic          out_valid,
    output logic [SW-1:0] stat_rd
);

    localparam int unsigned NL = DW / BW;
    localparam int unsigned OW = $clog2(NL);

    op_e           op;
    logic [DW-1:0] addr_res;
    logic [OW-1:0] addr_ofs;
    logic [DW-1:0] extr_res;
    logic [SW-1:0] stat_q;
    logic          addr_we;
    rslt_t         nxt;
    rslt_t         cur;

    assign op      = op_e'(in_op);
    assign addr_we = in_valid && (op == OP_ADDR);

    uxa_addr_gen #(.DW(DW), .OW(OW)) u_addr (
        .base    (opnd_a),
        .disp    (opnd_b),
        .aligned (addr_res),
        .ofs     (addr_ofs)
    );

    uxa_byte_funnel #(.DW(DW), .BW(BW), .OW(OW)) u_funnel (
        .hi  (opnd_a),
        .lo  (opnd_b),
        .ofs (stat_q[OW-1:0]),
        .out (extr_res)
    );

    uxa_status_reg #(.SW(SW), .OW(OW)) u_stat (
        .clk       (clk),
        .rst       (rst),
        .dir_we    (stat_we),
        .dir_wdata (stat_wdata),
        .addr_we   (addr_we),
        .addr_ofs  (addr_ofs),
        .stat      (stat_q)
    );

    always_comb begin
        nxt.vld = in_valid;
        unique case (op)
            OP_ADDR: nxt.data = addr_res;
            OP_EXTR: nxt.data = extr_res;
            default: nxt.data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else begin
            cur.vld <= nxt.vld;
            if (in_valid) cur.data <= nxt.data;
        end
    end

    assign result    = cur.data;
    assign out_valid = cur.vld;
    assign stat_rd   = stat_q;

    // R5: valid follows issue by one edge
    a_r5_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R5: idle cycle drops valid and holds the result
    a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(result)));

    // R1: address results are always aligned
    a_r1_aligned: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'b01) |=> (result[OW-1:0] == '0));

    // R10: null op codes return zero
    a_r10_null_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_op == 2'b00 || in_op == 2'b11)) |=> (result == '0));

    // R9: an extract never disturbs the status register without a direct write
    a_r9_extract_no_stat: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'b10 && !stat_we) |=> $stable(stat_rd));

endmodule

// File: tb/unaligned_extract_unit_test.sv
module unaligned_extract_unit_test;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [2:0]  ofs;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] exp;
    } vec_t;

    localparam logic [63:0] PA = 64'h0011223344556677;
    localparam logic [63:0] PB = 64'h8899AABBCCDDEEFF;

    localparam int NVEC = 10;
    localparam vec_t VEC [NVEC] = '{
        '{3'd0, PA, PB, PA},
        '{3'd1, PA, PB, 64'h1122334455667788},
        '{3'd2, PA, PB, 64'h2233445566778899},
        '{3'd3, PA, PB, 64'h33445566778899AA},
        '{3'd4, PA, PB, 64'h445566778899AABB},
        '{3'd5, PA, PB, 64'h5566778899AABBCC},
        '{3'd6, PA, PB, 64'h66778899AABBCCDD},
        '{3'd7, PA, PB, 64'h778899AABBCCDDEE},
        '{3'd5, 64'h0123456789ABCDEF, 64'hFEDCBA9876543210, 64'hABCDEFFEDCBA9876},
        '{3'd0, 64'h0123456789ABCDEF, 64'hFFFFFFFFFFFFFFFF, 64'h0123456789ABCDEF}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  in_op;
    logic [63:0] opnd_a;
    logic [63:0] opnd_b;
    logic        stat_we;
    logic [7:0]  stat_wdata;
    logic [63:0] result;
    logic        out_valid;
    logic [7:0]  stat_rd;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    unaligned_extract_unit uut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_op      (in_op),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .stat_we    (stat_we),
        .stat_wdata (stat_wdata),
        .result     (result),
        .out_valid  (out_valid),
        .stat_rd    (stat_rd)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [1:0] op, input logic [63:0] a,
                         input logic [63:0] b, input logic we, input logic [7:0] wd);
        in_valid   = v;
        in_op      = op;
        opnd_a     = a;
        opnd_b     = b;
        stat_we    = we;
        stat_wdata = wd;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 64'h0, 64'h1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        in_valid = 1'b0; in_op = 2'b00; opnd_a = '0; opnd_b = '0;
        stat_we = 1'b0; stat_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R6: reset state
        chk("R6 result", result, 64'h0);
        chk("R6 out_valid", {63'h0, out_valid}, 64'h0);
        chk("R6 status", {56'h0, stat_rd}, 64'h0);

        // Vector table: set offset directly, then extract (R3, R4, R9)
        for (int i = 0; i < NVEC; i++) begin
            drive(1'b0, 2'b00, '0, '0, 1'b1, {5'b0, VEC[i].ofs});
            drive(1'b1, 2'b10, VEC[i].a, VEC[i].b, 1'b0, 8'h00);
            chk(VEC[i].ofs == 3'd0 ? "R4 zero offset" : "R3 extract", result, VEC[i].exp);
            chk("R5 valid", {63'h0, out_valid}, 64'h1);
            chk("R9 extract keeps status", {56'h0, stat_rd}, {61'h0, VEC[i].ofs});
        end

        // R5/R10: operation with in_valid low is ignored, result held
        drive(1'b0, 2'b01, 64'h7, 64'h0, 1'b0, 8'h00);
        chk("R5 idle valid low", {63'h0, out_valid}, 64'h0);
        chk("R5 idle result held", result, VEC[NVEC-1].exp);
        chk("R10 invalid op no status change", {56'h0, stat_rd}, 64'h0);

        // R8: direct write of all bits
        drive(1'b0, 2'b00, '0, '0, 1'b1, 8'hA5);
        chk("R8 direct write", {56'h0, stat_rd}, 64'hA5);

        // R1/R2: address op
        drive(1'b1, 2'b01, 64'h10000003, 64'h6, 1'b0, 8'h00);
        chk("R1 aligned sum", result, 64'h10000008);
        chk("R2 field and upper bits", {56'h0, stat_rd}, 64'hA1);

        // R1/R2: wrap-around sum
        drive(1'b1, 2'b01, 64'hFFFFFFFFFFFFFFFF, 64'h3, 1'b0, 8'h00);
        chk("R1 wrap sum", result, 64'h0);
        chk("R2 wrap field", {56'h0, stat_rd}, 64'hA2);

        // R7: extract right behind the address op
        drive(1'b1, 2'b01, 64'h0, 64'h5, 1'b0, 8'h00);
        chk("R2 field 5", {56'h0, stat_rd}, 64'hA5);
        drive(1'b1, 2'b10, PA, PB, 1'b0, 8'h00);
        chk("R7 back-to-back extract", result, 64'h5566778899AABBCC);

        // R8: collision, address op wins
        drive(1'b1, 2'b01, 64'h20, 64'h6, 1'b1, 8'h3C);
        chk("R8 collision status", {56'h0, stat_rd}, 64'hA6);
        chk("R1 collision result", result, 64'h20);

        // R9: extract with same-cycle direct write uses old offset
        drive(1'b1, 2'b10, PA, PB, 1'b1, 8'h01);
        chk("R9 old offset used", result, 64'h66778899AABBCCDD);
        chk("R9 direct write after extract", {56'h0, stat_rd}, 64'h01);

        // R10: null op codes
        drive(1'b1, 2'b11, PA, PB, 1'b0, 8'h00);
        chk("R10 op 11 zero", result, 64'h0);
        chk("R10 op 11 status", {56'h0, stat_rd}, 64'h01);
        drive(1'b1, 2'b10, PA, PB, 1'b0, 8'h00);
        drive(1'b1, 2'b00, PA, PB, 1'b0, 8'h00);
        chk("R10 op 00 zero", result, 64'h0);
        chk("R10 op 00 valid", {63'h0, out_valid}, 64'h1);

        // R6: reset mid-run
        rst = 1'b1;
        drive(1'b1, 2'b10, PA, PB, 1'b0, 8'h00);
        rst = 1'b0;
        chk("R6 rerun result", result, 64'h0);
        chk("R6 rerun valid", {63'h0, out_valid}, 64'h0);
        chk("R6 rerun status", {56'h0, stat_rd}, 64'h0);
        drive(1'b0, 2'b00, '0, '0, 1'b0, 8'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule